// File: doc/BRIEF.md
# Isochronous Audio Sync Field Extractor

This block sits on the receive side of an isochronous audio link. Each packet starts with a two-quadlet bus header. After the header comes a run of sample slots, and each slot holds 28 quadlets, one per audio channel. Each quadlet carries a 24-bit audio word in its upper three bytes. Its low byte carries clock-tracking side information. The block drops the header quadlets and sends every audio word out on a valid/ready stream. Each word on that stream is tagged with its channel number and with a marker on the first channel of a slot.

The block collects the side bytes of each slot into four fields: a frame number, a phase value, a 16-bit receive sample counter and a 16-bit transmit buffer fill. It presents these fields for one cycle after the last quadlet of the slot. The side bytes of the first eight channels are repeated in the later channel groups. The block compares every copy against its original and reports any difference. It also reports a gap whenever the receive sample counter fails to advance by exactly one from the previous slot. The frame value is allowed to change from one slot to the next, including inside a packet, so each slot is captured on its own.

Top module: `iso_sync_extract`

## Requirements
- R1: For each payload quadlet, `out_data` equals bits 31:8 of that quadlet. The low byte never appears on the audio stream.
- R2: The quadlet presented with `in_sop`=1 and the one after it are header quadlets and produce no audio output. The third quadlet of the packet is channel 0 of the first slot.
- R3: Payload quadlets are tagged with channels 0,1,…,27, then 0 again. `out_sos` is 1 exactly on channel 0. A new `in_sop` abandons any partial slot, and the next payload starts again at channel 0.
- R4: `sync_valid` pulses for one cycle, in the cycle after channel 27 of a slot is accepted. While it is high, `sync_frame` is the low byte of channel 6 and `sync_phase` is the low byte of channel 7 of that slot.
- R5: While `sync_valid` is high, `sync_rx_count` is {low byte of channel 4, low byte of channel 1} and `sync_tx_size` is {low byte of channel 5, low byte of channel 0}, high byte first.
- R6: While `sync_valid` is high, `sync_err` is 1 if and only if, in that slot, some channel k in 8..27 has a low byte that differs from the low byte of channel k mod 8.
- R7: `sync_missed` is 1 only together with `sync_valid`. It is 1 when `sync_rx_count` differs from the previous slot's value plus one, modulo 65536. It is never 1 on the first slot after reset. A step from 0xFFFF to 0x0000 is not a miss.
- R8: Once `out_valid` is 1, it and `out_data`/`out_chan`/`out_sos` hold until `out_ready` is 1. `in_ready` is 1 whenever the output register is empty or is being drained.
- R9: Quadlets accepted after reset and before the first `in_sop` have no effect: they produce no audio output and no sync pulse.
- R10: During reset, and directly after it, `out_valid`, `sync_valid` and `sync_missed` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input quadlet present |
| in_ready | output | 1 | Input quadlet accepted this cycle when valid |
| in_data | input | 32 | Received quadlet |
| in_sop | input | 1 | Quadlet is the first header quadlet of a packet |
| out_valid | output | 1 | Audio word present |
| out_ready | input | 1 | Sink takes the audio word |
| out_data | output | 24 | Audio sample |
| out_chan | output | 5 | Channel index 0..27 |
| out_sos | output | 1 | Audio word is channel 0 of a slot |
| sync_valid | output | 1 | One-cycle pulse: slot fields valid |
| sync_frame | output | 8 | Frame number of the slot |
| sync_phase | output | 8 | Phase value of the slot |
| sync_rx_count | output | 16 | Receive sample counter |
| sync_tx_size | output | 16 | Transmit buffer fill |
| sync_err | output | 1 | A repeated side byte disagreed in the slot |
| sync_missed | output | 1 | Receive counter did not advance by one |

## Verification
The checks assume that `in_sop` is raised only on the first header quadlet. They also assume the sink deasserts `out_ready` only in ways that the valid/ready rule allows, and that no single-cycle sync pulse can be followed by another before 28 payload beats have passed. The bench keeps within these assumptions by building every packet as a `in_sop` header, one more header quadlet and then whole or deliberately truncated slots. It drives the sink's ready only from its own stall pattern. Corrupted copies, counter jumps, wrap-around and a packet restart partway through a slot are all produced from the table, within that same framing.

// File: rtl/iso_sync_pkg.sv
package iso_sync_pkg;
  localparam int NUM_CH    = 28;
  localparam int GROUP_CH  = 8;
  localparam int HDR_QUADS = 2;
  localparam int QUAD_W    = 32;
  localparam int SIDE_W    = 8;
  localparam int AUDIO_W   = QUAD_W - SIDE_W;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int GRP_W     = $clog2(GROUP_CH);
  localparam int CNT_W     = 2 * SIDE_W;

  // channel positions of the primary side bytes
  localparam int TXLO_CH  = 0;
  localparam int RXLO_CH  = 1;
  localparam int RXHI_CH  = 4;
  localparam int TXHI_CH  = 5;
  localparam int FRAME_CH = 6;
  localparam int PHASE_CH = 7;

  typedef struct packed {
    logic [SIDE_W-1:0] frame;
    logic [SIDE_W-1:0] phase;
    logic [CNT_W-1:0]  rx;
    logic [CNT_W-1:0]  tx;
    logic              err;
  } sync_rec_t;
endpackage

// File: rtl/iso_rst_sync.sv
module iso_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_no = sh_q[1];
endmodule

// File: rtl/iso_slot_tracker.sv
module iso_slot_tracker
  import iso_sync_pkg::*;
#(
  parameter int CHANNELS = NUM_CH,
  parameter int HDR      = HDR_QUADS
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                beat_i,
  input  logic                sop_i,
  output logic                payload_o,
  output logic [CH_W-1:0]     chan_o
);
  localparam int HW = $clog2(HDR + 1);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(CHANNELS - 1);
  localparam logic [HW-1:0]   HDR_REST = HW'(HDR - 1);

  logic              in_pkt_q, in_pkt_d;
  logic [HW-1:0]     hdr_q, hdr_d;
  logic [CH_W-1:0]   ch_q, ch_d;

  assign payload_o = beat_i && !sop_i && in_pkt_q && (hdr_q == '0);
  assign chan_o    = ch_q;

  always_comb begin
    in_pkt_d = in_pkt_q;
    hdr_d    = hdr_q;
    ch_d     = ch_q;
    if (beat_i) begin
      if (sop_i) begin
        in_pkt_d = 1'b1;
        hdr_d    = HDR_REST;
        ch_d     = '0;
      end else if (hdr_q != '0) begin
        hdr_d = hdr_q - HW'(1);
      end else if (in_pkt_q) begin
        ch_d = (ch_q == LAST_CH) ? '0 : ch_q + CH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      hdr_q    <= '0;
      ch_q     <= '0;
    end else if (beat_i) begin
      in_pkt_q <= in_pkt_d;
      hdr_q    <= hdr_d;
      ch_q     <= ch_d;
    end
  end

  // R3: channel index stays inside the slot
  a_r3_chan_range: assert property (@(posedge clk) disable iff (!rst_ni)
    ch_q <= LAST_CH);
endmodule

// File: rtl/iso_side_check.sv
module iso_side_check
  import iso_sync_pkg::*;
#(
  parameter int CHANNELS = NUM_CH,
  parameter int GROUP    = GROUP_CH
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               beat_i,
  input  logic [CH_W-1:0]    chan_i,
  input  logic [SIDE_W-1:0]  side_i,
  output logic               valid_o,
  output sync_rec_t          rec_o,
  output logic               missed_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(CHANNELS - 1);
  localparam logic [CH_W-1:0] GRP_LIM = CH_W'(GROUP);

  logic [SIDE_W-1:0] prim_q [GROUP];
  logic [GROUP-1:0]  wr;

  for (genvar g = 0; g < GROUP; g++) begin : g_prim
    assign wr[g] = beat_i && (chan_i == CH_W'(g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)    prim_q[g] <= '0;
      else if (wr[g]) prim_q[g] <= side_i;
    end
  end

  logic [SIDE_W-1:0] ref_byte;
  logic              mism, last;
  logic [CNT_W-1:0]  rx_now, tx_now, prev_inc;

  assign ref_byte = prim_q[chan_i[GRP_W-1:0]];
  assign mism     = beat_i && (chan_i >= GRP_LIM) && (side_i != ref_byte);
  assign last     = beat_i && (chan_i == LAST_CH);
  assign rx_now   = {prim_q[RXHI_CH], prim_q[RXLO_CH]};
  assign tx_now   = {prim_q[TXHI_CH], prim_q[TXLO_CH]};

  logic              acc_q, acc_d;
  logic              have_q, have_d;
  logic [CNT_W-1:0]  prev_q, prev_d;
  sync_rec_t         rec_q, rec_d;
  logic              valid_q, valid_d;
  logic              miss_q, miss_d;

  assign prev_inc = prev_q + CNT_W'(1);

  always_comb begin
    acc_d   = acc_q;
    have_d  = have_q;
    prev_d  = prev_q;
    rec_d   = rec_q;
    valid_d = last;
    miss_d  = 1'b0;
    if (beat_i && chan_i == '0) acc_d = 1'b0;
    else if (mism)              acc_d = 1'b1;
    if (last) begin
      rec_d.frame = prim_q[FRAME_CH];
      rec_d.phase = prim_q[PHASE_CH];
      rec_d.rx    = rx_now;
      rec_d.tx    = tx_now;
      rec_d.err   = acc_q | mism;
      miss_d      = have_q && (rx_now != prev_inc);
      prev_d      = rx_now;
      have_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= 1'b0;
      have_q  <= 1'b0;
      prev_q  <= '0;
      rec_q   <= '0;
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      miss_q  <= miss_d;
      if (beat_i) acc_q <= acc_d;
      if (last) begin
        have_q <= have_d;
        prev_q <= prev_d;
        rec_q  <= rec_d;
      end
    end
  end

  assign valid_o  = valid_q;
  assign rec_o    = rec_q;
  assign missed_o = miss_q;

  // R4: one pulse per slot
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R7: a gap is reported only inside the field window
  a_r7_miss_in_window: assert property (@(posedge clk) disable iff (!rst_ni)
    miss_q |-> valid_q);
endmodule

// File: rtl/iso_audio_stage.sv
module iso_audio_stage
  import iso_sync_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [AUDIO_W-1:0] data_i,
  input  logic [CH_W-1:0]    chan_i,
  input  logic               out_ready_i,
  output logic               in_ready_o,
  output logic               out_valid_o,
  output logic [AUDIO_W-1:0] out_data_o,
  output logic [CH_W-1:0]    out_chan_o,
  output logic               out_sos_o
);
  logic               vld_q, vld_d;
  logic [AUDIO_W-1:0] dat_q;
  logic [CH_W-1:0]    ch_q;
  logic               sos_q;

  assign in_ready_o = !vld_q || out_ready_i;

  always_comb begin
    vld_d = vld_q;
    if (load_i)           vld_d = 1'b1;
    else if (out_ready_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
      ch_q  <= '0;
      sos_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (load_i) begin
        dat_q <= data_i;
        ch_q  <= chan_i;
        sos_q <= (chan_i == '0);
      end
    end
  end

  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;
  assign out_chan_o  = ch_q;
  assign out_sos_o   = sos_q;

  // R8: stalled word holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (vld_q && !out_ready_i) |=> (vld_q && $stable(dat_q) && $stable(ch_q) && $stable(sos_q)));
  // R1: a loaded payload word is presented
  a_r1_load_shows: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |=> vld_q);
endmodule

// File: rtl/iso_sync_extract.sv
module iso_sync_extract
  import iso_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_sop,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [23:0] out_data,
  output logic [4:0]  out_chan,
  output logic        out_sos,
  output logic        sync_valid,
  output logic [7:0]  sync_frame,
  output logic [7:0]  sync_phase,
  output logic [15:0] sync_rx_count,
  output logic [15:0] sync_tx_size,
  output logic        sync_err,
  output logic        sync_missed
);
  logic            rst_ni;
  logic            accept, payload;
  logic [CH_W-1:0] chan;
  sync_rec_t       rec;

  iso_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_no(rst_ni));

  assign accept = in_valid && in_ready;

  iso_slot_tracker #(.CHANNELS(NUM_CH), .HDR(HDR_QUADS)) u_trk (
    .clk(clk), .rst_ni(rst_ni), .beat_i(accept), .sop_i(in_sop),
    .payload_o(payload), .chan_o(chan)
  );

  iso_side_check #(.CHANNELS(NUM_CH), .GROUP(GROUP_CH)) u_side (
    .clk(clk), .rst_ni(rst_ni), .beat_i(payload), .chan_i(chan),
    .side_i(in_data[SIDE_W-1:0]),
    .valid_o(sync_valid), .rec_o(rec), .missed_o(sync_missed)
  );

  iso_audio_stage u_aud (
    .clk(clk), .rst_ni(rst_ni), .load_i(payload),
    .data_i(in_data[QUAD_W-1:SIDE_W]), .chan_i(chan),
    .out_ready_i(out_ready), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .out_chan_o(out_chan), .out_sos_o(out_sos)
  );

  assign sync_frame    = rec.frame;
  assign sync_phase    = rec.phase;
  assign sync_rx_count = rec.rx;
  assign sync_tx_size  = rec.tx;
  assign sync_err      = rec.err;
endmodule

// File: tb/tb_iso_sync_extract.sv
module tb_iso_sync_extract;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_sop, out_valid, out_ready, out_sos;
  logic [31:0] in_data;
  logic [23:0] out_data;
  logic [4:0]  out_chan;
  logic sync_valid, sync_err, sync_missed;
  logic [7:0] sync_frame, sync_phase;
  logic [15:0] sync_rx_count, sync_tx_size;

  always #5 clk = ~clk;

  iso_sync_extract dut (.*);

  int total = 0;
  int bad = 0;
  int beats_seen = 0;
  bit done = 0;
  bit bp_en = 0;
  logic [7:0] lfsr = 8'hA5;
  bit have_prev = 0;
  logic [15:0] prev_rx = '0;
  logic [28:0] aq[$];
  logic [49:0] sq[$];

  // frame, phase, rx, tx, corrupted channel (0 = none)
  localparam int NV = 12;
  localparam logic [52:0] VEC [NV] = '{
    {8'h01, 8'h10, 16'h0005, 16'h0100, 5'd0},
    {8'h02, 8'h20, 16'h0006, 16'h0101, 5'd0},
    {8'h03, 8'h30, 16'h0007, 16'h0102, 5'd9},
    {8'h04, 8'h31, 16'h000A, 16'h0103, 5'd0},
    {8'h05, 8'h32, 16'h000B, 16'h01FF, 5'd27},
    {8'h06, 8'h33, 16'hFFFF, 16'h0000, 5'd0},
    {8'h07, 8'h34, 16'h0000, 16'h0001, 5'd0},
    {8'h07, 8'h35, 16'h0001, 16'h0002, 5'd16},
    {8'h08, 8'h36, 16'h0001, 16'h0003, 5'd0},
    {8'h09, 8'h37, 16'h0002, 16'h0004, 5'd24},
    {8'h0A, 8'h38, 16'h0003, 16'h8000, 5'd0},
    {8'h0B, 8'h39, 16'h0004, 16'h8001, 5'd12}
  };

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] audio_of(int s, int c);
    return 24'((s * 37 + c * 1021 + 7) * 97);
  endfunction

  task automatic send_q(logic [31:0] d, bit sop, bit exp, logic [4:0] ch);
    bit taken = 0;
    while (!taken) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp_en ? lfsr[0] : 1'b1;
      in_valid = 1'b1;
      in_data = d;
      in_sop = sop;
      #1;
      if (in_ready) begin
        taken = 1;
        if (exp) aq.push_back({ch, d[31:8]});
        @(posedge clk);
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sop = 1'b0;
      out_ready = 1'b1;
    end
  endtask

  task automatic send_hdr();
    send_q(32'hC0DE_0001, 1'b1, 1'b0, 5'd0);
    send_q(32'hC0DE_0002, 1'b0, 1'b0, 5'd0);
  endtask

  // nch < 28 produces a truncated slot with no sync expectation
  task automatic send_slot(int s, logic [52:0] v, int nch);
    logic [7:0] pb [8];
    logic [7:0] lb;
    logic [4:0] badc;
    bit miss;
    pb[0] = v[12:5];  pb[1] = v[28:21]; pb[2] = 8'(s + 8'h2C); pb[3] = 8'(s ^ 8'h5B);
    pb[4] = v[36:29]; pb[5] = v[20:13]; pb[6] = v[52:45];      pb[7] = v[44:37];
    badc = v[4:0];
    for (int c = 0; c < nch; c++) begin
      lb = pb[c % 8];
      if (badc != 0 && c == int'(badc)) lb = lb ^ 8'h40;
      if (c == 27) begin
        miss = have_prev && (v[36:21] != prev_rx + 16'd1);
        have_prev = 1;
        prev_rx = v[36:21];
        sq.push_back({v[52:45], v[44:37], v[36:21], v[20:5], (badc != 0), miss});
      end
      send_q({audio_of(s, c), lb}, 1'b0, 1'b1, 5'(c));
    end
  endtask

  // monitor: samples ahead of each rising edge
  logic        hold_pend = 0;
  logic [29:0] hold_val;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && !done) begin
        if (hold_pend)
          chk(out_valid && {out_chan, out_data, out_sos} == hold_val, "R8", "stall hold",
              {out_valid, out_chan, out_data, out_sos}, {1'b1, hold_val});
        hold_pend = out_valid && !out_ready;
        hold_val = {out_chan, out_data, out_sos};
        if (out_valid && out_ready) begin
          logic [28:0] e;
          beats_seen++;
          if (aq.size() == 0) begin
            chk(0, "R9", "unexpected audio beat", {out_chan, out_data}, 0);
          end else begin
            e = aq.pop_front();
            chk(out_chan == e[28:24], "R3", "channel", out_chan, e[28:24]);
            chk(out_data == e[23:0], "R1", "audio word", out_data, e[23:0]);
            chk(out_sos == (e[28:24] == 0), "R3", "start marker", out_sos, (e[28:24] == 0));
          end
        end
        if (sync_missed && !sync_valid) chk(0, "R7", "miss outside window", 1, 0);
        if (sync_valid) begin
          logic [49:0] x;
          if (sq.size() == 0) begin
            chk(0, "R4", "unexpected sync pulse", 1, 0);
          end else begin
            x = sq.pop_front();
            chk(sync_frame == x[49:42], "R4", "frame", sync_frame, x[49:42]);
            chk(sync_phase == x[41:34], "R4", "phase", sync_phase, x[41:34]);
            chk(sync_rx_count == x[33:18], "R5", "rx count", sync_rx_count, x[33:18]);
            chk(sync_tx_size == x[17:2], "R5", "tx size", sync_tx_size, x[17:2]);
            chk(sync_err == x[1], "R6", "copy mismatch", sync_err, x[1]);
            chk(sync_missed == x[0], "R7", "missed pulse", sync_missed, x[0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sop = 1'b0;
    in_data = '0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !sync_valid && !sync_missed && in_ready, "R10", "in reset",
        {out_valid, sync_valid, sync_missed, in_ready}, 4'b0001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!out_valid && !sync_valid && !sync_missed && in_ready, "R10", "after reset",
        {out_valid, sync_valid, sync_missed, in_ready}, 4'b0001);

    // R9: payload-like quadlets before any packet start
    for (int i = 0; i < 30; i++) send_q(32'h1234_5600 + 32'(i), 1'b0, 1'b0, 5'd0);
    idle(4);
    chk(beats_seen == 0, "R9", "beats before first start", beats_seen, 0);

    // table walk: 7 slots per packet, R2 header skip at each start
    for (int i = 0; i < NV; i++) begin
      if (i % 7 == 0) send_hdr();
      send_slot(i, VEC[i], 28);
    end
    idle(4);

    // R8: randomised sink stalls across two slots
    bp_en = 1;
    send_hdr();
    send_slot(20, {8'h21, 8'h40, 16'h0005, 16'h0A0A, 5'd0}, 28);
    send_slot(21, {8'h22, 8'h41, 16'h0006, 16'h0A0B, 5'd19}, 28);
    bp_en = 0;
    idle(4);

    // R3: packet restart abandons a partial slot
    send_hdr();
    send_slot(30, {8'h50, 8'h60, 16'h0100, 16'h0200, 5'd8}, 10);
    send_hdr();
    send_slot(31, {8'h51, 8'h61, 16'h0007, 16'h0201, 5'd0}, 28);
    idle(8);

    chk(aq.size() == 0, "R3", "audio beats outstanding", aq.size(), 0);
    chk(sq.size() == 0, "R4", "sync pulses outstanding", sq.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule